// File: doc/BRIEF.md
# Banked Dual-Write Register File

This block is the general-purpose register file of a small CPU core. It holds sixty-four registers of configurable width and lets the core retire two results per cycle through two write ports. It offers up to three operand reads per cycle, all combinational. Instead of a true multi-write memory, the storage is cut into four banks of sixteen entries. The two lowest address bits pick the bank, so two writes in one cycle can only collide when those two bits match. That collision is found by a 2-bit compare.

Each read port owns a complete copy of the storage, and every accepted write lands in every copy, so the read ports never contend with each other. When both write ports hit one bank, port 0 is applied, port 1 is discarded, and a conflict output is raised in that cycle so the pipeline can replay the lost result. Parameters reduce the block to a single write port and to two read ports for smaller cores.

Top module: `rf_banked_dual_write`

## Requirements
- R1: The file stores 64 registers addressed by a 6-bit index, and each read port returns, combinationally, the value of the register it addresses as last written.
- R2: Address bits [1:0] select the bank and bits [5:2] select the entry within the bank; registers that share a bank but differ in bits [5:2] never alias.
- R3: Two enabled writes whose addresses differ in bits [1:0] both take effect at the same clock edge.
- R4: `wr_conflict` is 1 in a cycle exactly when both write enables are 1 and both write addresses have equal bits [1:0]; otherwise it is 0.
- R5: On a conflict, port 0's write takes effect and port 1's write is discarded, including when both ports name the same register.
- R6: A read of a register that is written in the same cycle returns the value held before that clock edge.
- R7: All read ports work independently; any combination of read addresses, including all equal, returns correct data on every port.
- R8: When `rst` is 1 at a clock edge, every register in every copy becomes zero, and writes presented in that cycle are discarded.
- R9: With NUM_WR = 1 and NUM_RD = 2 the file accepts one write per cycle, serves two reads, and `wr_conflict` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wr_en | input | NUM_WR | Per-port write enable |
| wr_addr | input | NUM_WR x 6 | Per-port destination register index |
| wr_data | input | NUM_WR x DATA_W | Per-port write data |
| rd_addr | input | NUM_RD x 6 | Per-port source register index |
| rd_data | output | NUM_RD x DATA_W | Per-port read data, combinational |
| wr_conflict | output | 1 | Both writes hit the same bank this cycle |

## Verification
The bench builds two copies side by side: the default two-write, three-read, 64-bit file and a one-write, two-read file fed from the same stimulus. The first exposes bank conflicts, port-0 priority and read-copy independence under long random traffic with directed same-bank and same-register collisions. The second shows that the reduced build keeps the conflict output low and still stores every write. A reset issued while writes are in flight shows that the clear reaches every replicated copy in both builds.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int RF_REGS   = 64;
    localparam int RF_BANKS  = 4;
    localparam int RF_DEPTH  = RF_REGS / RF_BANKS;
    localparam int RF_ADDR_W = $clog2(RF_REGS);
    localparam int RF_BANK_W = $clog2(RF_BANKS);
    localparam int RF_IDX_W  = $clog2(RF_DEPTH);

    typedef logic [RF_ADDR_W-1:0] reg_idx_t;

    typedef struct packed {
        logic [RF_IDX_W-1:0]  entry;
        logic [RF_BANK_W-1:0] bank;
    } bank_loc_t;

    function automatic bank_loc_t split_addr(input reg_idx_t a);
        bank_loc_t loc;
        loc.bank  = a[RF_BANK_W-1:0];
        loc.entry = a[RF_ADDR_W-1:RF_BANK_W];
        return loc;
    endfunction

endpackage

// File: rtl/rf_bank.sv
module rf_bank
    import rf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [RF_IDX_W-1:0] widx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [RF_IDX_W-1:0] ridx,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] mem [RF_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RF_DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/rf_wr_arbiter.sv
module rf_wr_arbiter
    import rf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NUM_WR = 2
) (
    input  logic [NUM_WR-1:0]                 wr_en,
    input  logic [NUM_WR-1:0][RF_ADDR_W-1:0]  wr_addr,
    input  logic [NUM_WR-1:0][DATA_W-1:0]     wr_data,
    output logic [RF_BANKS-1:0]               bk_we,
    output logic [RF_BANKS-1:0][RF_IDX_W-1:0] bk_idx,
    output logic [RF_BANKS-1:0][DATA_W-1:0]   bk_data,
    output logic                              conflict
);

    localparam int CNT_W = $clog2(NUM_WR + 1);

    bank_loc_t                      loc [NUM_WR];
    logic [RF_BANKS-1:0][CNT_W-1:0] hits;

    always_comb begin
        for (int p = 0; p < NUM_WR; p++) begin
            loc[p] = split_addr(wr_addr[p]);
        end
    end

    // Lower-numbered ports are applied last, so port 0 has the final say.
    always_comb begin
        bk_we   = '0;
        bk_idx  = '0;
        bk_data = '0;
        for (int p = NUM_WR - 1; p >= 0; p--) begin
            if (wr_en[p]) begin
                bk_we[loc[p].bank]   = 1'b1;
                bk_idx[loc[p].bank]  = loc[p].entry;
                bk_data[loc[p].bank] = wr_data[p];
            end
        end
    end

    always_comb begin
        hits     = '0;
        conflict = 1'b0;
        for (int p = 0; p < NUM_WR; p++) begin
            if (wr_en[p]) begin
                hits[loc[p].bank] = hits[loc[p].bank] + CNT_W'(1);
            end
        end
        for (int b = 0; b < RF_BANKS; b++) begin
            if (hits[b] > CNT_W'(1)) begin
                conflict = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [RF_ADDR_W-1:0]              rd_addr,
    input  logic [RF_BANKS-1:0][DATA_W-1:0]   bank_q,
    output logic [RF_IDX_W-1:0]               entry,
    output logic [DATA_W-1:0]                 rd_data
);

    bank_loc_t loc;

    assign loc     = split_addr(rd_addr);
    assign entry   = loc.entry;
    assign rd_data = bank_q[loc.bank];

endmodule

// File: rtl/rf_banked_dual_write.sv
module rf_banked_dual_write
    import rf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NUM_WR = 2,
    parameter int NUM_RD = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_WR-1:0]                 wr_en,
    input  logic [NUM_WR-1:0][RF_ADDR_W-1:0]  wr_addr,
    input  logic [NUM_WR-1:0][DATA_W-1:0]     wr_data,
    input  logic [NUM_RD-1:0][RF_ADDR_W-1:0]  rd_addr,
    output logic [NUM_RD-1:0][DATA_W-1:0]     rd_data,
    output logic                              wr_conflict
);

    logic [RF_BANKS-1:0]                           bk_we;
    logic [RF_BANKS-1:0][RF_IDX_W-1:0]             bk_idx;
    logic [RF_BANKS-1:0][DATA_W-1:0]               bk_data;
    logic [NUM_RD-1:0][RF_IDX_W-1:0]               rd_entry;
    logic [NUM_RD-1:0][RF_BANKS-1:0][DATA_W-1:0]   bank_q;

    rf_wr_arbiter #(
        .DATA_W (DATA_W),
        .NUM_WR (NUM_WR)
    ) u_arb (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .bk_we    (bk_we),
        .bk_idx   (bk_idx),
        .bk_data  (bk_data),
        .conflict (wr_conflict)
    );

    for (genvar c = 0; c < NUM_RD; c++) begin : g_copy
        rf_read_port #(
            .DATA_W (DATA_W)
        ) u_rp (
            .rd_addr (rd_addr[c]),
            .bank_q  (bank_q[c]),
            .entry   (rd_entry[c]),
            .rd_data (rd_data[c])
        );
        for (genvar b = 0; b < RF_BANKS; b++) begin : g_bank
            rf_bank #(
                .DATA_W (DATA_W)
            ) u_bank (
                .clk   (clk),
                .rst   (rst),
                .we    (bk_we[b]),
                .widx  (bk_idx[b]),
                .wdata (bk_data[b]),
                .ridx  (rd_entry[c]),
                .rdata (bank_q[c][b])
            );
        end
    end

endmodule

// File: rtl/rf_banked_checker.sv
module rf_banked_checker
    import rf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NUM_WR = 2,
    parameter int NUM_RD = 3
) (
    input logic                              clk,
    input logic                              rst,
    input logic [NUM_WR-1:0]                 wr_en,
    input logic [NUM_WR-1:0][RF_ADDR_W-1:0]  wr_addr,
    input logic [NUM_WR-1:0][DATA_W-1:0]     wr_data,
    input logic [NUM_RD-1:0][RF_ADDR_W-1:0]  rd_addr,
    input logic [NUM_RD-1:0][DATA_W-1:0]     rd_data,
    input logic                              wr_conflict
);

    p_port0_lands_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en[0]) && !$past(rst) && rd_addr[0] == $past(wr_addr[0]))
        |-> rd_data[0] == $past(wr_data[0]));

    for (genvar k = 0; k < NUM_RD; k++) begin : g_rst
        p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> rd_data[k] == '0);
    end

    if (NUM_RD > 1) begin : g_rd
        p_copies_agree_r7: assert property (@(posedge clk) disable iff (rst)
            (rd_addr[0] == rd_addr[1]) |-> rd_data[0] == rd_data[1]);
    end

    if (NUM_WR > 1) begin : g_wr
        p_conflict_needs_both_r4: assert property (@(posedge clk) disable iff (rst)
            wr_conflict |-> (wr_en[0] && wr_en[1]));
        p_conflict_same_bank_r4: assert property (@(posedge clk) disable iff (rst)
            wr_conflict |-> (wr_addr[0][RF_BANK_W-1:0] == wr_addr[1][RF_BANK_W-1:0]));
        p_split_banks_free_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_en[0] && wr_en[1] &&
             wr_addr[0][RF_BANK_W-1:0] != wr_addr[1][RF_BANK_W-1:0]) |-> !wr_conflict);
        p_port1_lands_r3: assert property (@(posedge clk) disable iff (rst)
            ($past(wr_en[1]) && !$past(wr_conflict) && !$past(rst) &&
             rd_addr[0] == $past(wr_addr[1]))
            |-> rd_data[0] == $past(wr_data[1]));
    end else begin : g_single
        p_no_conflict_r9: assert property (@(posedge clk) disable iff (rst)
            wr_en[0] |-> !wr_conflict);
    end

endmodule

bind rf_banked_dual_write rf_banked_checker #(
    .DATA_W (DATA_W),
    .NUM_WR (NUM_WR),
    .NUM_RD (NUM_RD)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr_conflict (wr_conflict)
);

// File: tb/tb_rf_banked_dual_write.sv
module tb_rf_banked_dual_write;

    localparam int DW = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                 rst;
    logic [1:0]           wr_en;
    logic [1:0][5:0]      wr_addr;
    logic [1:0][DW-1:0]   wr_data;
    logic [2:0][5:0]      rd_addr;
    logic [2:0][DW-1:0]   rd_data;
    logic                 wr_conflict;
    logic [1:0][DW-1:0]   rd1_data;
    logic                 conflict1;

    rf_banked_dual_write #(.DATA_W(DW), .NUM_WR(2), .NUM_RD(3)) dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .wr_conflict (wr_conflict)
    );

    rf_banked_dual_write #(.DATA_W(DW), .NUM_WR(1), .NUM_RD(2)) dut_1w (
        .clk (clk), .rst (rst), .wr_en (wr_en[0]), .wr_addr (wr_addr[0]),
        .wr_data (wr_data[0]), .rd_addr (rd_addr[1:0]), .rd_data (rd1_data),
        .wr_conflict (conflict1)
    );

    logic [DW-1:0] model   [64];
    logic [DW-1:0] model1w [64];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inputs are set at the negedge; outputs are sampled 1 ns later; the model
    // advances at the following posedge.
    task automatic step(input string tag);
        logic exp_c;
        #1;
        exp_c = wr_en[0] && wr_en[1] && (wr_addr[0][1:0] == wr_addr[1][1:0]);
        if (!rst) begin
            chk("R4 conflict", {63'd0, wr_conflict}, {63'd0, exp_c});
            chk("R9 conflict", {63'd0, conflict1}, 64'd0);
        end
        for (int p = 0; p < 3; p++) chk(tag, rd_data[p], model[rd_addr[p]]);
        for (int p = 0; p < 2; p++) chk("R9 read", rd1_data[p], model1w[rd_addr[p]]);
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 64; i++) begin
                model[i]   = '0;
                model1w[i] = '0;
            end
        end else begin
            if (wr_en[1] && !(wr_en[0] && wr_addr[0][1:0] == wr_addr[1][1:0]))
                model[wr_addr[1]] = wr_data[1];
            if (wr_en[0]) begin
                model[wr_addr[0]]   = wr_data[0];
                model1w[wr_addr[0]] = wr_data[0];
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = '0;
    endtask

    task automatic scan_all(input string tag);
        idle();
        for (int i = 0; i < 64; i++) begin
            rd_addr = {6'(i), 6'(i), 6'(i)};
            step(tag);
        end
    endtask

    initial begin
        rst = 1'b1; wr_en = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        for (int i = 0; i < 64; i++) begin
            model[i] = 'x; model1w[i] = 'x;
        end
        @(posedge clk);
        for (int i = 0; i < 64; i++) begin
            model[i] = '0; model1w[i] = '0;
        end
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state, all copies
        scan_all("R8 reset state");

        // R3: two banks in one cycle
        wr_en = 2'b11; wr_addr[0] = 6'd5; wr_addr[1] = 6'd6;
        wr_data[0] = 64'hAAAA_0005; wr_data[1] = 64'hBBBB_0006;
        step("R3 write");
        idle(); rd_addr = {6'd6, 6'd5, 6'd5};
        step("R3 readback");
        chk("R3 port1 value", rd_data[2], 64'hBBBB_0006);

        // R5: same bank, different registers
        wr_en = 2'b11; wr_addr[0] = 6'd4; wr_addr[1] = 6'd8;
        wr_data[0] = 64'h1111; wr_data[1] = 64'h2222;
        step("R5 conflict cycle");
        idle(); rd_addr = {6'd8, 6'd4, 6'd4};
        step("R5 readback");
        chk("R5 port1 dropped", rd_data[2], 64'd0);
        chk("R5 port0 kept", rd_data[0], 64'h1111);

        // R5: same register on both ports
        wr_en = 2'b11; wr_addr[0] = 6'd9; wr_addr[1] = 6'd9;
        wr_data[0] = 64'h3333; wr_data[1] = 64'h4444;
        step("R5 same reg cycle");
        idle(); rd_addr = {6'd9, 6'd9, 6'd9};
        step("R5 same reg readback");
        chk("R5 same reg value", rd_data[1], 64'h3333);

        // R6: read while writing
        wr_en = 2'b01; wr_addr[0] = 6'd5; wr_data[0] = 64'h5555;
        rd_addr = {6'd5, 6'd5, 6'd5};
        #1 chk("R6 old value", rd_data[0], 64'hAAAA_0005);
        step("R6 read during write");

        // R2: same bank, different entries
        wr_en = 2'b01; wr_addr[0] = 6'd2; wr_data[0] = 64'hCAFE;
        step("R2 write a");
        wr_addr[0] = 6'd18; wr_data[0] = 64'hBEEF;
        step("R2 write b");
        idle(); rd_addr = {6'd50, 6'd18, 6'd2};
        step("R2 readback");
        chk("R2 entry a", rd_data[0], 64'hCAFE);
        chk("R2 entry b", rd_data[1], 64'hBEEF);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            wr_en = 2'($urandom);
            wr_addr[0] = 6'($urandom); wr_addr[1] = 6'($urandom);
            if (n % 7 == 0) wr_addr[1] = {wr_addr[1][5:2], wr_addr[0][1:0]};
            wr_data[0] = {$urandom, $urandom}; wr_data[1] = {$urandom, $urandom};
            rd_addr = {6'($urandom), 6'($urandom), 6'($urandom)};
            if (n % 5 == 0) rd_addr = {rd_addr[0], rd_addr[0], rd_addr[0]};
            step("R1/R7 random read");
        end

        // R8: reset with writes presented
        wr_en = 2'b11; wr_addr[0] = 6'd7; wr_addr[1] = 6'd12;
        wr_data[0] = 64'h7777; wr_data[1] = 64'hCCCC;
        rst = 1'b1;
        step("R8 reset cycle");
        rst = 1'b0;
        scan_all("R8 cleared");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule